// File: doc/BRIEF.md
# Chip-Select Generator with Wait-State Timing

This block drives one active-low chip select and a bus-cycle termination signal for an asynchronous external bus. A separate comparator reports whether the current address falls in the window of this select. The block adds the remaining qualifications from a 16-bit option word: transfer direction, byte lane, function space and interrupt level. It then times the assertion to either the address strobe or the data strobe.

Once a qualified cycle begins, a wait-state counter produces an internal acknowledge after a programmed number of clocks. One code acknowledges a clock earlier than the zero-wait case, and another code hands termination to an external acknowledge input. In an interrupt-acknowledge cycle the block can request an autovector instead of acknowledging. Synchronous operation is a stub: with the mode bit set, no cycle starts.

Option word layout, most significant bit first: sync-mode [15], lane [14:13], direction [12:11], strobe-select [10], wait code [9:6], space [5:4], level [3:1], autovector [0]. All of its fields are zero after reset.

Top module: `cs_waitgen`

## Requirements
- R1: A cycle starts only on a clock edge where the address strobe is high, `addr_hit` is 1, `fc_space` equals the space field [5:4], and the direction, lane and level checks below all pass. Otherwise `cs_n` stays 1.
- R2: After reset, `cs_n` is 1 and both `int_ack` and `avec_req` are 0.
- R3: The direction field [12:11] works as follows, with `rd_wr`=1 meaning a read: 00 never selects, 01 selects reads only, 10 selects writes only, 11 selects both.
- R4: With `port_wide`=1, the lane field [14:13] is checked against the lanes the access touches. A word access (`size_word`=1) touches both lanes; a byte access with `addr_lsb`=0 touches the upper lane and one with `addr_lsb`=1 touches the lower lane. Lane codes: 00 never selects, 01 selects if the lower lane is touched, 10 selects if the upper lane is touched, 11 always selects. With `port_wide`=0 the lane field is ignored.
- R5: For a wait code W from 0 to 13 in bits [9:6], `int_ack` rises W+1 clocks after the edge that starts the cycle. It then stays high until the cycle ends.
- R6: Wait code 14 raises `int_ack` on the same edge that starts the cycle, one clock earlier than W=0.
- R7: With strobe-select [10]=0, `cs_n` falls on the starting edge. With [10]=1, it falls on the first edge within the cycle where the data strobe is high.
- R8: On the first edge where the address strobe is sampled low, `cs_n` returns to 1 and `int_ack` and `avec_req` return to 0.
- R9: Wait code 15 produces no internal acknowledge. While a cycle is active, `int_ack` follows `ext_ack`.
- R10: Space code 3 is interrupt acknowledge. In that space the cycle starts only if `irq_level` equals the level field [3:1], or if that field is 0. If the autovector bit [0] is 1, `avec_req` rises on the starting edge and `int_ack` stays 0 for the whole cycle.
- R11: With sync-mode [15]=1, no cycle starts and `cs_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| opt_word | input | 16 | Option word |
| addr_hit | input | 1 | Address window match from the base comparator |
| rd_wr | input | 1 | 1 = read, 0 = write |
| adr_strobe | input | 1 | Address strobe, active high, spans the cycle |
| dat_strobe | input | 1 | Data strobe, active high |
| fc_space | input | 2 | Function-space code of the access |
| irq_level | input | 3 | Interrupt level being acknowledged |
| port_wide | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| addr_lsb | input | 1 | Address bit 0 |
| size_word | input | 1 | 1 = word access, 0 = byte access |
| ext_ack | input | 1 | External termination input |
| cs_n | output | 1 | Chip select, active low |
| int_ack | output | 1 | Cycle termination |
| avec_req | output | 1 | Autovector request |

## Verification
The checker assumes that the option word and the access attributes change only while the address strobe is low. It also assumes that the data strobe never rises outside an address-strobe window. Several properties compare a value with its one-cycle-earlier state, so they rely on these rules. The bench obeys them: every task programs the option word and the attributes at a falling clock edge while the address strobe is idle. Only after that does it raise the strobes, and it lowers both strobes together at the end of each access.

// File: rtl/cs_opt_pkg.sv
package cs_opt_pkg;

   localparam int CS_LANE_W  = 2;
   localparam int CS_DIR_W   = 2;
   localparam int CS_WAIT_W  = 4;
   localparam int CS_SPACE_W = 2;
   localparam int CS_LVL_W   = 3;

   // Packed MSB first, so a cast of the option word maps fields in place
   typedef struct packed {
      logic                  sync_mode;
      logic [CS_LANE_W-1:0]  lane;
      logic [CS_DIR_W-1:0]   dir;
      logic                  on_data;
      logic [CS_WAIT_W-1:0]  wait_code;
      logic [CS_SPACE_W-1:0] space;
      logic [CS_LVL_W-1:0]   level;
      logic                  autovec;
   } cs_opt_t;

   localparam int CS_OPT_W = $bits(cs_opt_t);

endpackage

// File: rtl/cs_qualify.sv
module cs_qualify
   import cs_opt_pkg::*;
#(
   parameter logic [CS_SPACE_W-1:0] IACK_SPACE = '1
) (
   input  cs_opt_t               opt,
   input  logic                  addr_hit,
   input  logic                  rd_wr,
   input  logic [CS_SPACE_W-1:0] fc_space,
   input  logic [CS_LVL_W-1:0]   irq_level,
   input  logic                  port_wide,
   input  logic                  addr_lsb,
   input  logic                  size_word,
   output logic                  match,
   output logic                  iack
);

   logic dir_ok, lane_ok, lvl_ok, touch_up, touch_lo;

   always_comb begin
      dir_ok   = rd_wr ? opt.dir[0] : opt.dir[1];
      touch_up = size_word | ~addr_lsb;
      touch_lo = size_word | addr_lsb;
      if (!port_wide) begin
         lane_ok = 1'b1;
      end else begin
         unique case (opt.lane)
            2'b00:   lane_ok = 1'b0;
            2'b01:   lane_ok = touch_lo;
            2'b10:   lane_ok = touch_up;
            default: lane_ok = 1'b1;
         endcase
      end
      iack   = (fc_space == IACK_SPACE);
      lvl_ok = !iack || (opt.level == '0) || (opt.level == irq_level);
      match  = addr_hit && !opt.sync_mode && (fc_space == opt.space)
               && dir_ok && lane_ok && lvl_ok;
   end

endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer #(
   parameter int WAIT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              busy,
   input  logic              stop,
   input  logic [WAIT_W-1:0] code,
   output logic              ack_q
);

   localparam logic [WAIT_W-1:0] CODE_EXT  = '1;
   localparam logic [WAIT_W-1:0] CODE_FAST = CODE_EXT - 1'b1;
   localparam logic [WAIT_W-1:0] CNT_TOP   = '1;

   logic [WAIT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         ack_q <= 1'b0;
      end else if (stop) begin
         cnt   <= '0;
         ack_q <= 1'b0;
      end else if (start) begin
         cnt   <= '0;
         ack_q <= (code == CODE_FAST);
      end else if (busy) begin
         if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
         if (code < CODE_FAST && cnt == code) ack_q <= 1'b1;
      end
   end

endmodule

// File: rtl/cs_waitgen.sv
module cs_waitgen
   import cs_opt_pkg::*;
#(
   parameter logic [CS_SPACE_W-1:0] IACK_SPACE  = '1,
   parameter bit                    EXT_ACK_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [CS_OPT_W-1:0]   opt_word,
   input  logic                  addr_hit,
   input  logic                  rd_wr,
   input  logic                  adr_strobe,
   input  logic                  dat_strobe,
   input  logic [CS_SPACE_W-1:0] fc_space,
   input  logic [CS_LVL_W-1:0]   irq_level,
   input  logic                  port_wide,
   input  logic                  addr_lsb,
   input  logic                  size_word,
   input  logic                  ext_ack,
   output logic                  cs_n,
   output logic                  int_ack,
   output logic                  avec_req
);

   localparam logic [CS_WAIT_W-1:0] CODE_EXT = '1;

   initial begin
      if (CS_OPT_W != 16) $error("option word must be 16 bits");
      if (CS_WAIT_W < 2)  $error("wait code needs at least 2 bits");
   end

   cs_opt_t opt;
   logic    match, iack, start, act, sel_q, avec_q, tmr_ack, ext_path;

   assign opt   = cs_opt_t'(opt_word);
   assign start = adr_strobe && !act && match;

   cs_qualify #(.IACK_SPACE(IACK_SPACE)) u_qual (
      .opt      (opt),
      .addr_hit (addr_hit),
      .rd_wr    (rd_wr),
      .fc_space (fc_space),
      .irq_level(irq_level),
      .port_wide(port_wide),
      .addr_lsb (addr_lsb),
      .size_word(size_word),
      .match    (match),
      .iack     (iack)
   );

   cs_wait_timer #(.WAIT_W(CS_WAIT_W)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .start(start),
      .busy (act),
      .stop (!adr_strobe),
      .code (opt.wait_code),
      .ack_q(tmr_ack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act    <= 1'b0;
         sel_q  <= 1'b0;
         avec_q <= 1'b0;
      end else if (!adr_strobe) begin
         act    <= 1'b0;
         sel_q  <= 1'b0;
         avec_q <= 1'b0;
      end else begin
         if (start) begin
            act    <= 1'b1;
            avec_q <= iack && opt.autovec;
         end
         if ((start && !opt.on_data) ||
             ((act || start) && opt.on_data && dat_strobe))
            sel_q <= 1'b1;
      end
   end

   generate
      if (EXT_ACK_REG) begin : g_ext_reg
         logic ext_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ext_q <= 1'b0;
            else        ext_q <= ext_ack && adr_strobe && (act || start);
         end
         assign ext_path = ext_q && act;
      end else begin : g_ext_comb
         assign ext_path = ext_ack && act;
      end
   endgenerate

   assign cs_n     = !sel_q;
   assign avec_req = avec_q;
   assign int_ack  = !avec_q &&
                     ((opt.wait_code == CODE_EXT) ? ext_path : tmr_ack);

endmodule

// File: rtl/cs_waitgen_chk.sv
module cs_waitgen_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [15:0] opt_word,
   input logic        addr_hit,
   input logic        adr_strobe,
   input logic        cs_n,
   input logic        int_ack,
   input logic        avec_req
);

   AST_RELEASE_ON_AS: assert property (@(posedge clk) disable iff (!rst_n)
      !adr_strobe |=> (cs_n && !int_ack && !avec_req)); // R8

   AST_START_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n) && !opt_word[10] && $stable(opt_word))
         |-> $past(addr_hit && adr_strobe)); // R1

   AST_AVEC_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      avec_req |-> !int_ack); // R10

   AST_FAST_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cs_n) && !opt_word[10] && opt_word[9:6] == 4'd14 && !avec_req)
         |-> int_ack); // R6

   AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && adr_strobe && opt_word[9:6] != 4'd15) |=> int_ack); // R5

   AST_SYNC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (opt_word[15] && cs_n && $stable(opt_word)) |=> cs_n); // R11

endmodule

bind cs_waitgen cs_waitgen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .opt_word  (opt_word),
   .addr_hit  (addr_hit),
   .adr_strobe(adr_strobe),
   .cs_n      (cs_n),
   .int_ack   (int_ack),
   .avec_req  (avec_req)
);

// File: tb/cs_waitgen_test.sv
module cs_waitgen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] opt_word = '0;
   logic        addr_hit = 0, rd_wr = 1, adr_strobe = 0, dat_strobe = 0;
   logic [1:0]  fc_space = 2'd1;
   logic [2:0]  irq_level = 3'd0;
   logic        port_wide = 0, addr_lsb = 0, size_word = 0, ext_ack = 0;
   logic        cs_n, int_ack, avec_req;

   int checks = 0, fails = 0;

   always #2 clk = ~clk;

   cs_waitgen uut (.*);

   function automatic logic [15:0] mk(input logic md, input logic [1:0] ln,
      input logic [1:0] dr, input logic od, input logic [3:0] wc,
      input logic [1:0] sp, input logic [2:0] lv, input logic av);
      return {md, ln, dr, od, wc, sp, lv, av};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Runs one access with both strobes high; returns first observed
   // negedge index (1-based) of cs low, int_ack high, avec_req high, or -1
   task automatic access(input logic [15:0] o, input logic rd,
      input logic [1:0] sp, input logic [2:0] lv, input logic hit,
      input logic wide, input logic lsb, input logic wd,
      output int k_cs, output int k_ack, output int k_av);
      @(negedge clk);
      opt_word = o; rd_wr = rd; fc_space = sp; irq_level = lv;
      addr_hit = hit; port_wide = wide; addr_lsb = lsb; size_word = wd;
      @(negedge clk);
      adr_strobe = 1; dat_strobe = 1;
      k_cs = -1; k_ack = -1; k_av = -1;
      for (int k = 1; k <= 18; k++) begin
         @(negedge clk);
         if (k_cs  < 0 && !cs_n)    k_cs  = k;
         if (k_ack < 0 && int_ack)  k_ack = k;
         if (k_av  < 0 && avec_req) k_av  = k;
      end
      adr_strobe = 0; dat_strobe = 0;
      @(negedge clk);
      chk("R8 release", {cs_n, int_ack, avec_req}, 3'b100);
   endtask

   task automatic t_reset;
      chk("R2 reset", {cs_n, int_ack, avec_req}, 3'b100);
   endtask

   task automatic t_waits;
      int c, a, v;
      access(mk(0, 2'b11, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R7 cs on AS", c, 1);
      chk("R5 W=0", a, 2);
      access(mk(0, 2'b11, 2'b11, 0, 4'd3, 2'd1, 0, 0), 1, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R5 W=3", a, 5);
      access(mk(0, 2'b11, 2'b11, 0, 4'd13, 2'd1, 0, 0), 0, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R5 W=13", a, 15);
      access(mk(0, 2'b11, 2'b11, 0, 4'd14, 2'd1, 0, 0), 1, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R6 fast cs", c, 1);
      chk("R6 fast ack", a, 1);
   endtask

   task automatic t_qualify;
      int c, a, v;
      access(mk(0, 2'b11, 2'b01, 0, 4'd0, 2'd1, 0, 0), 0, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R3 read-only on write", c, -1);
      access(mk(0, 2'b11, 2'b10, 0, 4'd0, 2'd1, 0, 0), 0, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R3 write-only on write", c, 1);
      access(mk(0, 2'b11, 2'b00, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R3 disabled", c, -1);
      access(mk(0, 2'b11, 2'b11, 0, 4'd0, 2'd2, 0, 0), 1, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R1 space mismatch", c, -1);
      access(mk(0, 2'b11, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 0, 0, 0, 0, c, a, v);
      chk("R1 no hit", c, -1);
      access(mk(1, 2'b11, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R11 sync stub", c, -1);
   endtask

   task automatic t_lanes;
      int c, a, v;
      access(mk(0, 2'b01, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 1, 0, 0, c, a, v);
      chk("R4 lower lane, even byte", c, -1);
      access(mk(0, 2'b01, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 1, 1, 0, c, a, v);
      chk("R4 lower lane, odd byte", c, 1);
      access(mk(0, 2'b10, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 1, 1, 0, c, a, v);
      chk("R4 upper lane, odd byte", c, -1);
      access(mk(0, 2'b10, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 1, 1, 1, c, a, v);
      chk("R4 upper lane, word", c, 1);
      access(mk(0, 2'b00, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 1, 0, 1, c, a, v);
      chk("R4 lane disabled", c, -1);
      access(mk(0, 2'b00, 2'b11, 0, 4'd0, 2'd1, 0, 0), 1, 1, 0, 1, 0, 0, 0, c, a, v);
      chk("R4 narrow port ignores lane", c, 1);
   endtask

   task automatic t_data_strobe;
      int k_cs;
      @(negedge clk);
      opt_word = mk(0, 2'b11, 2'b11, 1, 4'd0, 2'd1, 0, 0);
      rd_wr = 0; fc_space = 1; addr_hit = 1; port_wide = 0;
      @(negedge clk);
      adr_strobe = 1;
      @(negedge clk);
      @(negedge clk);
      chk("R7 no cs before DS", cs_n, 1);
      dat_strobe = 1;
      k_cs = -1;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         if (k_cs < 0 && !cs_n) k_cs = k;
      end
      chk("R7 cs after DS", k_cs, 1);
      adr_strobe = 0; dat_strobe = 0;
      @(negedge clk);
      chk("R8 release DS mode", cs_n, 1);
   endtask

   task automatic t_external;
      @(negedge clk);
      opt_word = mk(0, 2'b11, 2'b11, 0, 4'd15, 2'd1, 0, 0);
      rd_wr = 1; fc_space = 1; addr_hit = 1; port_wide = 0; ext_ack = 0;
      @(negedge clk);
      adr_strobe = 1; dat_strobe = 1;
      for (int k = 0; k < 18; k++) @(negedge clk);
      chk("R9 no internal ack", int_ack, 0);
      ext_ack = 1;
      #1;
      chk("R9 ext ack passes", int_ack, 1);
      @(negedge clk);
      ext_ack = 0;
      #1;
      chk("R9 ext ack drops", int_ack, 0);
      adr_strobe = 0; dat_strobe = 0;
      @(negedge clk);
      chk("R8 release ext", cs_n, 1);
   endtask

   task automatic t_iack;
      int c, a, v;
      access(mk(0, 2'b11, 2'b11, 0, 4'd0, 2'd3, 3'd5, 0), 1, 3, 3'd4, 1, 0, 0, 0, c, a, v);
      chk("R10 level mismatch", c, -1);
      access(mk(0, 2'b11, 2'b11, 0, 4'd0, 2'd3, 3'd5, 0), 1, 3, 3'd5, 1, 0, 0, 0, c, a, v);
      chk("R10 level match", c, 1);
      access(mk(0, 2'b11, 2'b11, 0, 4'd0, 2'd3, 3'd0, 0), 1, 3, 3'd6, 1, 0, 0, 0, c, a, v);
      chk("R10 level 0 any", c, 1);
      access(mk(0, 2'b11, 2'b11, 0, 4'd0, 2'd3, 3'd0, 1), 1, 3, 3'd2, 1, 0, 0, 0, c, a, v);
      chk("R10 autovector req", v, 1);
      chk("R10 autovector no ack", a, -1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_waits();
      t_qualify();
      t_lanes();
      t_data_strobe();
      t_external();
      t_iack();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule